// File: doc/BRIEF.md
# Two-Level Debug Breakpoint Trigger Unit

This block watches a processor while it keeps running. It observes the issued program counter and the operand address and data of each local-bus cycle. Three comparators look for a breakpoint:

- The program counter is compared under a mask.
- The bus address is checked against an inclusive range.
- The bus data is compared under a mask.

Each trigger level selects any subset of the three comparators. A selected comparator that fires is a hit for that level.

The trigger sequencer can run with one level or with two. In two-level mode the level-2 condition is only armed once level 1 has fired. On the final trigger the block produces the programmed response: status display only, a one-cycle halt pulse, or a one-cycle debug-interrupt pulse. A program-counter break is signalled combinationally in the issue cycle, so the processor can act before the instruction executes. A bus break is held as a pending request until the processor acknowledges it.

The breakpoint state is shown in two forms. One is a 4-bit nibble for the trace port. The other is a 4-bit code in the status register. Reading the status register clears a completed trigger. Rewriting either trigger-control register re-arms the unit or disables it.

Top module: `dbg_trig_unit`

## Requirements
- R1: While reset is asserted and after it is released, the status nibble and status code are 0000, and the halt pulse, interrupt pulse, bus-pending and PC-break outputs are 0.
- R2: The state encodings (nibble/code) are: off 0000/0000, wait level 1 0010/0001, level 1 fired 0100/0010, wait level 2 1010/0101, level 2 fired 1100/0110. A write to address 0 or 1 sets the state to wait level 1 if the level-1 enable (address 0, bit 0) is 1 after the write, and to off otherwise. This clears any fired status. The write takes priority over a hit in the same cycle.
- R3: The PC comparator hits when pcValid is 1 and pcValue equals the target (address 2) in every bit where the PC mask (address 3) is 0. Mask bits set to 1 are ignored.
- R4: The address comparator hits when busValid is 1 and the low bound (address 4) <= busAddr <= the high bound (address 5). Both bounds are inclusive.
- R5: The data comparator hits when busValid is 1 and busData equals the data target (address 6) in every bit where the data mask (address 7) is 0.
- R6: Level-1 select is address 0 bits 6:4 (bit 4 PC, bit 5 address, bit 6 data). In wait level 1, a level-1 hit with level 2 disabled (address 1, bit 0 = 0) moves the state to level 1 fired and is the final trigger.
- R7: Level-2 select is address 1 bits 6:4, with the same bit order as level 1. In wait level 1 with level 2 enabled, a level-1 hit moves the state to wait level 2 with no response. Level-2 hits in wait level 1 have no effect. In wait level 2, a level-2 hit moves the state to level 2 fired and is the final trigger.
- R8: The response is set by address 0 bits 2:1. 01 gives haltPulse high for exactly the one cycle after the final trigger. 10 gives dbgIrqPulse in the same way. 00 and 11 give neither pulse. A fired state ignores further hits.
- R9: pcBreakReq is high combinationally in the cycle of a final trigger when the response is 01 or 10 and a selected PC comparator hit.
- R10: After a final trigger with response 01 or 10 in which a selected address or data comparator hit, busPending goes to 1 and stays 1 until a cycle with bkptAck high. A new set in the same cycle wins over the acknowledge.
- R11: A cycle with statusRd high moves the state from level 2 fired, or from level 1 fired with level 2 disabled, back to wait level 1. In the wait and off states it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 3 | Configuration register select |
| cfgData | input | XLEN | Configuration write data |
| statusRd | input | 1 | Status register read strobe |
| pcValid | input | 1 | Instruction issue strobe |
| pcValue | input | XLEN | Program counter of issued instruction |
| busValid | input | 1 | Local-bus cycle strobe |
| busAddr | input | XLEN | Operand address |
| busData | input | XLEN | Operand data |
| bkptAck | input | 1 | Processor acceptance of a pending bus break |
| statusNibble | output | 4 | Trace-port breakpoint status nibble |
| statusCode | output | 4 | Status register breakpoint field |
| pcBreakReq | output | 1 | Precise PC break request |
| busPending | output | 1 | Pending bus break request |
| haltPulse | output | 1 | One-cycle halt request |
| dbgIrqPulse | output | 1 | One-cycle debug interrupt request |

## Verification
Directed cases first exercise each comparator on its own:

- A PC that differs only in masked bits, and one that differs in an unmasked bit. These separate the masking from a plain equality test.
- Addresses one below, exactly on, and one above each range bound. These expose off-by-one errors in the range.
- Data values that differ in masked and in unmasked bits.

Level-1 hits arriving while level 2 is enabled, and level-2 hits arriving before level 1 has fired, separate the two-level sequence from the one-level one. Status reads in every state show which states the read may clear. A long random run with occasional reconfiguration then mixes simultaneous PC and bus hits, writes that collide with hits, and acknowledges that arrive late or in the same cycle. The outcomes are compared with a bench model.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

  // state value is the status code; the trace nibble is the code shifted left
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_WAIT1 = 3'd1,
    ST_HIT1  = 3'd2,
    ST_WAIT2 = 3'd5,
    ST_HIT2  = 3'd6
  } trigState_t;

  typedef enum logic [1:0] {
    RSP_SHOW  = 2'b00,
    RSP_HALT  = 2'b01,
    RSP_IRQ   = 2'b10,
    RSP_SHOWB = 2'b11
  } trigResp_t;

  // bit order matches the select field: bit0 PC, bit1 address, bit2 data
  typedef struct packed {
    logic dataHit;
    logic addrHit;
    logic pcHit;
  } cmpHits_t;

  typedef struct packed {
    logic       lvl1En;
    logic       lvl2En;
    trigResp_t  resp;
    logic [2:0] sel1;
    logic [2:0] sel2;
  } trigCfg_t;

  typedef struct packed {
    cmpHits_t hits;
    logic     rearm;
    logic     rearmEn;
  } dpStrobes_t;

  localparam int CFG_AW = 3;
  localparam logic [CFG_AW-1:0] A_CTL1   = 3'd0;
  localparam logic [CFG_AW-1:0] A_CTL2   = 3'd1;
  localparam logic [CFG_AW-1:0] A_PCTGT  = 3'd2;
  localparam logic [CFG_AW-1:0] A_PCMSK  = 3'd3;
  localparam logic [CFG_AW-1:0] A_ADRLO  = 3'd4;
  localparam logic [CFG_AW-1:0] A_ADRHI  = 3'd5;
  localparam logic [CFG_AW-1:0] A_DATTGT = 3'd6;
  localparam logic [CFG_AW-1:0] A_DATMSK = 3'd7;

endpackage

// File: rtl/dbg_masked_cmp.sv
module dbg_masked_cmp #(
  parameter int W = 32
) (
  input  logic         valid,
  input  logic [W-1:0] value,
  input  logic [W-1:0] target,
  input  logic [W-1:0] ignore,
  output logic         hit
);
  always_comb hit = valid && (((value ^ target) & ~ignore) == '0);
endmodule

// File: rtl/dbg_trig_datapath.sv
module dbg_trig_datapath
  import dbg_trig_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [XLEN-1:0]   cfgData,
  input  logic              pcValid,
  input  logic [XLEN-1:0]   pcValue,
  input  logic              busValid,
  input  logic [XLEN-1:0]   busAddr,
  input  logic [XLEN-1:0]   busData,
  output trigCfg_t          cfg,
  output dpStrobes_t        strb
);
  localparam int NREG = 1 << CFG_AW;

  logic [XLEN-1:0] valReg [NREG];
  logic [NREG-1:0] wrSel;

  always_comb begin
    for (int i = 0; i < NREG; i++) wrSel[i] = cfgWrEn && (cfgAddr == CFG_AW'(i));
  end

  // value registers at addresses 2..7
  for (genvar g = 2; g < NREG; g++) begin : g_val
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         valReg[g] <= '0;
      else if (wrSel[g]) valReg[g] <= cfgData;
    end
  end
  assign valReg[0] = '0;
  assign valReg[1] = '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= '0;
    end else begin
      if (wrSel[A_CTL1]) begin
        cfg.lvl1En <= cfgData[0];
        cfg.resp   <= trigResp_t'(cfgData[2:1]);
        cfg.sel1   <= cfgData[6:4];
      end
      if (wrSel[A_CTL2]) begin
        cfg.lvl2En <= cfgData[0];
        cfg.sel2   <= cfgData[6:4];
      end
    end
  end

  dbg_masked_cmp #(.W(XLEN)) u_pcCmp (
    .valid(pcValid), .value(pcValue),
    .target(valReg[A_PCTGT]), .ignore(valReg[A_PCMSK]),
    .hit(strb.hits.pcHit)
  );

  dbg_masked_cmp #(.W(XLEN)) u_dataCmp (
    .valid(busValid), .value(busData),
    .target(valReg[A_DATTGT]), .ignore(valReg[A_DATMSK]),
    .hit(strb.hits.dataHit)
  );

  always_comb begin
    strb.hits.addrHit = busValid && (busAddr >= valReg[A_ADRLO]) && (busAddr <= valReg[A_ADRHI]);
    strb.rearm        = wrSel[A_CTL1] || wrSel[A_CTL2];
    strb.rearmEn      = wrSel[A_CTL1] ? cfgData[0] : cfg.lvl1En;
  end

endmodule

// File: rtl/dbg_trig_ctrl.sv
module dbg_trig_ctrl
  import dbg_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  trigCfg_t   cfg,
  input  dpStrobes_t strb,
  input  logic       statusRd,
  input  logic       bkptAck,
  output trigState_t state,
  output logic       pcBreakReq,
  output logic       busPending,
  output logic       haltPulse,
  output logic       dbgIrqPulse
);
  trigState_t stNext;
  logic       lvl1Hit, lvl2Hit, fire, busCause, pcCause, respActive;

  always_comb begin
    lvl1Hit    = |(cfg.sel1 & strb.hits);
    lvl2Hit    = |(cfg.sel2 & strb.hits);
    respActive = (cfg.resp == RSP_HALT) || (cfg.resp == RSP_IRQ);
    stNext     = state;
    fire       = 1'b0;
    busCause   = 1'b0;
    pcCause    = 1'b0;
    if (strb.rearm) begin
      stNext = strb.rearmEn ? ST_WAIT1 : ST_OFF;
    end else if (statusRd && ((state == ST_HIT1 && !cfg.lvl2En) || state == ST_HIT2)) begin
      stNext = ST_WAIT1;
    end else begin
      unique case (state)
        ST_WAIT1: if (lvl1Hit) begin
          if (cfg.lvl2En) stNext = ST_WAIT2;
          else begin
            stNext   = ST_HIT1;
            fire     = 1'b1;
            pcCause  = cfg.sel1[0] && strb.hits.pcHit;
            busCause = |(cfg.sel1[2:1] & {strb.hits.dataHit, strb.hits.addrHit});
          end
        end
        ST_WAIT2: if (lvl2Hit) begin
          stNext   = ST_HIT2;
          fire     = 1'b1;
          pcCause  = cfg.sel2[0] && strb.hits.pcHit;
          busCause = |(cfg.sel2[2:1] & {strb.hits.dataHit, strb.hits.addrHit});
        end
        default: ;
      endcase
    end
    pcBreakReq = fire && respActive && pcCause;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_OFF;
      haltPulse   <= 1'b0;
      dbgIrqPulse <= 1'b0;
      busPending  <= 1'b0;
    end else begin
      state       <= stNext;
      haltPulse   <= fire && (cfg.resp == RSP_HALT);
      dbgIrqPulse <= fire && (cfg.resp == RSP_IRQ);
      if (fire && respActive && busCause) busPending <= 1'b1;
      else if (bkptAck)                   busPending <= 1'b0;
    end
  end

endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
  import dbg_trig_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgWrEn,
  input  logic [2:0]      cfgAddr,
  input  logic [XLEN-1:0] cfgData,
  input  logic            statusRd,
  input  logic            pcValid,
  input  logic [XLEN-1:0] pcValue,
  input  logic            busValid,
  input  logic [XLEN-1:0] busAddr,
  input  logic [XLEN-1:0] busData,
  input  logic            bkptAck,
  output logic [3:0]      statusNibble,
  output logic [3:0]      statusCode,
  output logic            pcBreakReq,
  output logic            busPending,
  output logic            haltPulse,
  output logic            dbgIrqPulse
);
  trigCfg_t   cfg;
  dpStrobes_t strb;
  trigState_t state;

  dbg_trig_datapath #(.XLEN(XLEN)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .pcValid(pcValid), .pcValue(pcValue), .busValid(busValid), .busAddr(busAddr),
    .busData(busData), .cfg(cfg), .strb(strb)
  );

  dbg_trig_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfg(cfg), .strb(strb), .statusRd(statusRd), .bkptAck(bkptAck),
    .state(state), .pcBreakReq(pcBreakReq), .busPending(busPending),
    .haltPulse(haltPulse), .dbgIrqPulse(dbgIrqPulse)
  );

  assign statusCode   = {1'b0, state};
  assign statusNibble = {state, 1'b0};

endmodule

// File: rtl/dbg_trig_unit_chk.sv
module dbg_trig_unit_chk (
  input logic       clk,
  input logic       rstN,
  input logic       bkptAck,
  input logic [3:0] statusNibble,
  input logic       busPending,
  input logic       haltPulse,
  input logic       dbgIrqPulse
);
  p_reset_state_r1: assert property (@(posedge clk) !rstN |=> (statusNibble == 4'h0 && !busPending));

  p_legal_code_r2: assert property (@(posedge clk) disable iff (!rstN)
    statusNibble inside {4'h0, 4'h2, 4'h4, 4'hA, 4'hC});

  p_lvl2_from_wait_r7: assert property (@(posedge clk) disable iff (!rstN)
    (statusNibble == 4'hC && $past(statusNibble) != 4'hC) |-> $past(statusNibble) == 4'hA);

  p_halt_single_r8: assert property (@(posedge clk) disable iff (!rstN) haltPulse |=> !haltPulse);

  p_irq_single_r8: assert property (@(posedge clk) disable iff (!rstN) dbgIrqPulse |=> !dbgIrqPulse);

  p_one_response_r8: assert property (@(posedge clk) disable iff (!rstN) !(haltPulse && dbgIrqPulse));

  p_pulse_in_fired_r6: assert property (@(posedge clk) disable iff (!rstN)
    (haltPulse || dbgIrqPulse) |-> (statusNibble == 4'h4 || statusNibble == 4'hC));

  p_pending_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busPending && !bkptAck) |=> busPending);
endmodule

bind dbg_trig_unit dbg_trig_unit_chk u_chk (
  .clk(clk), .rstN(rstN), .bkptAck(bkptAck), .statusNibble(statusNibble),
  .busPending(busPending), .haltPulse(haltPulse), .dbgIrqPulse(dbgIrqPulse)
);

// File: tb/dbg_trig_unit_tb.sv
module dbg_trig_unit_tb;
  localparam int XL = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, cfgWrEn, statusRd, pcValid, busValid, bkptAck;
  logic [2:0] cfgAddr;
  logic [XL-1:0] cfgData, pcValue, busAddr, busData;
  logic [3:0] statusNibble, statusCode;
  logic pcBreakReq, busPending, haltPulse, dbgIrqPulse;

  dbg_trig_unit #(.XLEN(XL)) u_dut (.*);

  int errs = 0, checks = 0;
  bit done = 0;

  // bench model of the requirements
  logic [XL-1:0] mReg [8];
  logic mEn1, mEn2, mPend;
  logic [1:0] mResp;
  logic [2:0] mSel1, mSel2, mSt;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic wr, input logic [2:0] wa, input logic [XL-1:0] wd,
                      input logic rd, input logic pv, input logic [XL-1:0] pc,
                      input logic bv, input logic [XL-1:0] ba, input logic [XL-1:0] bd,
                      input logic ack);
    logic pcH, aH, dH, h1, h2, fin, act, pcC, busC;
    logic [2:0] hv, nSt;
    @(negedge clk);
    cfgWrEn = wr; cfgAddr = wa; cfgData = wd; statusRd = rd;
    pcValid = pv; pcValue = pc; busValid = bv; busAddr = ba; busData = bd; bkptAck = ack;
    #1;
    pcH = pv && (((pc ^ mReg[2]) & ~mReg[3]) == '0);
    aH  = bv && ba >= mReg[4] && ba <= mReg[5];
    dH  = bv && (((bd ^ mReg[6]) & ~mReg[7]) == '0);
    hv  = {dH, aH, pcH};
    h1  = |(mSel1 & hv);
    h2  = |(mSel2 & hv);
    nSt = mSt; fin = 0; pcC = 0; busC = 0;
    if (wr && wa <= 3'd1) nSt = ((wa == 3'd0) ? wd[0] : mEn1) ? 3'd1 : 3'd0;
    else if (rd && ((mSt == 3'd2 && !mEn2) || mSt == 3'd6)) nSt = 3'd1;
    else if (mSt == 3'd1 && h1) begin
      if (mEn2) nSt = 3'd5;
      else begin nSt = 3'd2; fin = 1; pcC = mSel1[0] && pcH; busC = |(mSel1[2:1] & {dH, aH}); end
    end else if (mSt == 3'd5 && h2) begin
      nSt = 3'd6; fin = 1; pcC = mSel2[0] && pcH; busC = |(mSel2[2:1] & {dH, aH});
    end
    act = fin && (mResp == 2'b01 || mResp == 2'b10);
    chk("R9", pcBreakReq, act && pcC);
    @(posedge clk); #1;
    if (wr) begin
      mReg[wa] = wd;
      if (wa == 3'd0) begin mEn1 = wd[0]; mResp = wd[2:1]; mSel1 = wd[6:4]; end
      if (wa == 3'd1) begin mEn2 = wd[0]; mSel2 = wd[6:4]; end
    end
    if (act && busC) mPend = 1; else if (ack) mPend = 0;
    mSt = nSt;
    chk("R2", statusNibble, {mSt, 1'b0});
    chk("R2", statusCode, {1'b0, mSt});
    chk("R8", haltPulse, fin && mResp == 2'b01);
    chk("R8", dbgIrqPulse, fin && mResp == 2'b10);
    chk("R10", busPending, mPend);
  endtask

  task automatic wrc(input logic [2:0] a, input logic [XL-1:0] d);
    step(1, a, d, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic rdc(); step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0); endtask
  task automatic pcs(input logic [XL-1:0] p); step(0, 0, 0, 0, 1, p, 0, 0, 0, 0); endtask
  task automatic bus(input logic [XL-1:0] a, input logic [XL-1:0] d);
    step(0, 0, 0, 0, 0, 0, 1, a, d, 0);
  endtask
  task automatic idle(input logic ack); step(0, 0, 0, 0, 0, 0, 0, 0, 0, ack); endtask

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    for (int i = 0; i < 8; i++) mReg[i] = '0;
    mEn1 = 0; mEn2 = 0; mPend = 0; mResp = 0; mSel1 = 0; mSel2 = 0; mSt = 0;
    rstN = 0; cfgWrEn = 0; cfgAddr = 0; cfgData = 0; statusRd = 0;
    pcValid = 0; pcValue = 0; busValid = 0; busAddr = 0; busData = 0; bkptAck = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", statusNibble, 0); chk("R1", statusCode, 0);
    chk("R1", haltPulse, 0); chk("R1", dbgIrqPulse, 0); chk("R1", busPending, 0);
    rstN = 1;
    idle(0);
    chk("R1", statusNibble, 0);

    // one level, PC with mask, halt
    wrc(3'd2, 32'h100); wrc(3'd3, 32'h0F); wrc(3'd1, 0);
    wrc(3'd0, 32'h13);
    chk("R2", statusNibble, 4'h2); chk("R2", statusCode, 4'h1);
    pcs(32'h205); chk("R3", statusNibble, 4'h2);
    pcs(32'h10A); chk("R3", statusNibble, 4'h4); chk("R6", statusCode, 4'h2);
    chk("R8", haltPulse, 1);
    pcs(32'h100); chk("R8", haltPulse, 0); chk("R6", statusNibble, 4'h4);
    rdc(); chk("R11", statusNibble, 4'h2);

    // two level: address range then data, interrupt
    wrc(3'd4, 32'h1000); wrc(3'd5, 32'h1FFF); wrc(3'd6, 32'hAB00); wrc(3'd7, 32'hFF);
    wrc(3'd1, 32'h41); wrc(3'd0, 32'h25);
    bus(32'h0FFF, 0); chk("R4", statusNibble, 4'h2);
    bus(32'h3000, 32'hAB00); chk("R7", statusNibble, 4'h2);
    bus(32'h1000, 0); chk("R7", statusNibble, 4'hA); chk("R7", statusCode, 4'h5);
    chk("R7", dbgIrqPulse, 0);
    rdc(); chk("R11", statusNibble, 4'hA);
    bus(32'h3000, 32'hAB12); chk("R7", statusNibble, 4'hC); chk("R7", statusCode, 4'h6);
    chk("R8", dbgIrqPulse, 1); chk("R10", busPending, 1);
    idle(0); idle(0); chk("R10", busPending, 1); chk("R8", dbgIrqPulse, 0);
    idle(1); chk("R10", busPending, 0);
    rdc(); chk("R11", statusNibble, 4'h2);

    // one level address upper bound, then just past it
    wrc(3'd1, 0); wrc(3'd0, 32'h25);
    bus(32'h1FFF, 0); chk("R4", statusNibble, 4'h4);
    idle(1);
    rdc(); chk("R11", statusNibble, 4'h2);
    bus(32'h2000, 0); chk("R4", statusNibble, 4'h2);

    // data mask, display only
    wrc(3'd0, 32'h41);
    bus(0, 32'hAC00); chk("R5", statusNibble, 4'h2);
    bus(0, 32'hABFF); chk("R5", statusNibble, 4'h4);
    chk("R8", haltPulse, 0); chk("R8", dbgIrqPulse, 0);
    wrc(3'd0, 0); chk("R2", statusNibble, 4'h0); chk("R2", statusCode, 4'h0);
    rdc(); chk("R11", statusNibble, 4'h0);

    // random run with small values so comparators hit often
    wrc(3'd2, 5); wrc(3'd3, 3); wrc(3'd4, 6); wrc(3'd5, 12); wrc(3'd6, 9); wrc(3'd7, 4);
    wrc(3'd0, 32'h73);
    for (int i = 0; i < 6000; i++) begin
      logic w; logic [2:0] a; logic [XL-1:0] d;
      w = ($urandom % 40) == 0;
      a = 3'($urandom % 8);
      d = (a <= 3'd1) ? XL'({$urandom % 8, 1'b0, $urandom % 8}) | XL'(($urandom % 4) != 0)
                      : XL'($urandom % 32);
      step(w, a, d, ($urandom % 10) == 0, $urandom % 2, XL'($urandom % 32),
           $urandom % 2, XL'($urandom % 32), XL'($urandom % 32), ($urandom % 8) == 0);
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule